// File: doc/BRIEF.md
# Ethernet DMA Control Register File

This block is the software-visible control surface of a small Ethernet DMA controller. A processor reaches it over a plain 32-bit register bus: a write strobe with offset and data, and a read strobe whose data comes back on the following cycle. The block holds the interrupt cause and mask, and it drives one level-sensitive interrupt line. It also holds a PHY management word whose read responses are synthesized locally, a receive-offset selection bit, and the descriptor pointers for two transmit queues and four receive queues.

The transmit and receive engines sit next to it. Transmit start commands go out to the transmit engine as single-cycle pulses, with the high-priority queue always kicked ahead of the low one. Each write to a receive queue's current pointer also produces a one-cycle load pulse, so the receive engine can copy that pointer into its working copy. Completion events from the engines set cause bits, and software acknowledges them by writing a mask of bits to keep.

Top module: `ethregs_top`

## Requirements
- R1: After reset every register reads as zero, `irq` is low, and no start or load pulse is driven.
- R2: A write to the cause register (offset 0x450) replaces the cause with the bitwise AND of the old cause and the written data, so a bit is cleared by writing 0 to it.
- R3: `rxDoneEvt` sets cause bit 0, `txDoneEvt[1]` (high queue) sets cause bit 2 and `txDoneEvt[0]` (low queue) sets cause bit 3, one cycle after the event. An event in the same cycle as a cause write still leaves its bit set.
- R4: The mask register (offset 0x458) stores the written value and reads it back. `irq` is high exactly when cause AND mask is non-zero.
- R5: A read of the PHY management register (offset 0x010) returns zero when bit 26 (read opcode) of the stored word is clear.
- R6: When stored bit 26 is set, a PHY read returns bit 27 (read valid) together with a 16-bit value chosen by the stored bits 25:16. Code 0x021 gives 0x000C, code 0x041 gives 0x0141, code 0x061 gives 0x0E20, and any other code gives 0.
- R7: Bit 28 of a port-config write (offset 0x408) drives `rxOffsetTwo` (1 selects a 2-byte receive offset). A read of that register returns only bit 28.
- R8: A write to current-RX pointer n (offset 0x4A0 + 4n) stores the value on `rxCurPtr` slice n and pulses `rxWorkLoad[n]` for one cycle in the following cycle.
- R9: The first-RX pointers (0x480 + 4n) and current-TX pointers (0x4E0 + 4n, with n = 0 for the low queue) store the written values, appear on their output slices, and read back.
- R10: A write to the DMA command register (0x448) with bit 23 set pulses `txStartHi` in the next cycle. With bit 22 set alone, it pulses `txStartLo` in the next cycle. With both bits set, `txStartHi` pulses in the next cycle and `txStartLo` pulses in the cycle after that.
- R11: Writes to unmapped offsets change nothing. Reads of unmapped offsets, and of the write-only DMA command register, return zero.
- R12: Read data appears on `rdData` in the cycle after `rdEn`, and `rdData` is zero in any cycle that follows one without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, one cycle after rdEn |
| irq | output | 1 | Level interrupt, cause AND mask non-zero |
| rxDoneEvt | input | 1 | Receive-done event from receive engine |
| txDoneEvt | input | 2 | Transmit-done events, index 1 high queue, index 0 low queue |
| txStartHi | output | 1 | One-cycle start pulse for the high transmit queue |
| txStartLo | output | 1 | One-cycle start pulse for the low transmit queue |
| rxWorkLoad | output | 4 | Per-queue pulse to load the receive working pointer |
| rxOffsetTwo | output | 1 | Selects the 2-byte receive data offset |
| rxFirstPtr | output | 128 | Four first-RX pointers, queue n in bits 32n+31:32n |
| rxCurPtr | output | 128 | Four current-RX pointers, queue n in bits 32n+31:32n |
| txCurPtr | output | 64 | Two current-TX pointers, queue n in bits 32n+31:32n |

## Verification
The hardest situation to reach is a cause write that lands in the same cycle as a completion event. Here the AND-clear and the event-set compete for the same bit. The stimulus holds `rxDoneEvt` high through the clearing write's cycle, and a behavioural model predicts the surviving bit. A second awkward case is the deferred low-queue start after a dual command. The bench leaves idle cycles after that command so that every cycle of the two-pulse sequence is compared against the model.

// File: rtl/ethregs_pkg.sv
package ethregs_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int NUM_RX = 4;
  localparam int NUM_TX = 2;
  localparam int STRIDE = 4;

  localparam logic [ADDR_W-1:0] OFF_PHY      = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_PORT     = 12'h408;
  localparam logic [ADDR_W-1:0] OFF_CMD      = 12'h448;
  localparam logic [ADDR_W-1:0] OFF_CAUSE    = 12'h450;
  localparam logic [ADDR_W-1:0] OFF_MASK     = 12'h458;
  localparam logic [ADDR_W-1:0] OFF_FIRST_RX = 12'h480;
  localparam logic [ADDR_W-1:0] OFF_CUR_RX   = 12'h4A0;
  localparam logic [ADDR_W-1:0] OFF_CUR_TX   = 12'h4E0;

  localparam int CMD_HI_BIT   = 23;
  localparam int CMD_LO_BIT   = 22;
  localparam int PORT_OFF_BIT = 28;
  localparam int PHY_OP_BIT   = 26;
  localparam int PHY_VAL_BIT  = 27;
  localparam int RX_DONE_BIT  = 0;
  localparam int TX_DONE_TOP  = 3;   // queue q sets bit TX_DONE_TOP - q

  localparam logic [9:0]  PHY_CODE_STATUS = 10'h021;
  localparam logic [9:0]  PHY_CODE_ID_HI  = 10'h041;
  localparam logic [9:0]  PHY_CODE_ID_LO  = 10'h061;
  localparam logic [15:0] PHY_STATUS_VAL  = 16'h000C;
  localparam logic [15:0] PHY_ID_HI_VAL   = 16'h0141;
  localparam logic [15:0] PHY_ID_LO_VAL   = 16'h0E20;

  typedef struct packed {
    logic              phy;
    logic              port;
    logic              cmd;
    logic              cause;
    logic              mask;
    logic [NUM_RX-1:0] firstRx;
    logic [NUM_RX-1:0] curRx;
    logic [NUM_TX-1:0] curTx;
  } regSel_t;
endpackage

// File: rtl/ethregs_ctrl.sv
module ethregs_ctrl
  import ethregs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cmdHiBit,
  input  logic              cmdLoBit,
  output regSel_t           wrSel,
  output regSel_t           rdSel,
  output logic              txStartHi,
  output logic              txStartLo,
  output logic [NUM_RX-1:0] rxWorkLoad
);
  regSel_t hit;
  logic    loDeferred;

  always_comb begin
    hit       = '0;
    hit.phy   = (addr == OFF_PHY);
    hit.port  = (addr == OFF_PORT);
    hit.cmd   = (addr == OFF_CMD);
    hit.cause = (addr == OFF_CAUSE);
    hit.mask  = (addr == OFF_MASK);
    for (int i = 0; i < NUM_RX; i++) begin
      hit.firstRx[i] = (addr == OFF_FIRST_RX + ADDR_W'(STRIDE * i));
      hit.curRx[i]   = (addr == OFF_CUR_RX + ADDR_W'(STRIDE * i));
    end
    for (int q = 0; q < NUM_TX; q++) begin
      hit.curTx[q] = (addr == OFF_CUR_TX + ADDR_W'(STRIDE * q));
    end
  end

  assign wrSel = wrEn ? hit : '0;
  assign rdSel = rdEn ? hit : '0;

  // High queue is kicked first; a low kick issued together with it is held one cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txStartHi  <= 1'b0;
      txStartLo  <= 1'b0;
      loDeferred <= 1'b0;
      rxWorkLoad <= '0;
    end else begin
      txStartHi  <= wrSel.cmd & cmdHiBit;
      txStartLo  <= loDeferred | (wrSel.cmd & cmdLoBit & ~cmdHiBit);
      loDeferred <= wrSel.cmd & cmdLoBit & cmdHiBit;
      rxWorkLoad <= wrSel.curRx;
    end
  end
endmodule

// File: rtl/ethregs_dp.sv
module ethregs_dp
  import ethregs_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  regSel_t                  wrSel,
  input  regSel_t                  rdSel,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     rxDoneEvt,
  input  logic [NUM_TX-1:0]        txDoneEvt,
  output logic [DATA_W-1:0]        rdData,
  output logic                     irq,
  output logic                     rxOffsetTwo,
  output logic [NUM_RX*DATA_W-1:0] rxFirstPtr,
  output logic [NUM_RX*DATA_W-1:0] rxCurPtr,
  output logic [NUM_TX*DATA_W-1:0] txCurPtr
);
  logic [DATA_W-1:0] phyReg, cause, mask;
  logic              portOff;
  logic [DATA_W-1:0] firstRx [NUM_RX];
  logic [DATA_W-1:0] curRx   [NUM_RX];
  logic [DATA_W-1:0] curTx   [NUM_TX];
  logic [DATA_W-1:0] evtBits, causeNext, phyResp, rdNext;

  always_comb begin
    evtBits = '0;
    evtBits[RX_DONE_BIT] = rxDoneEvt;
    for (int q = 0; q < NUM_TX; q++) evtBits[TX_DONE_TOP - q] = txDoneEvt[q];
    causeNext = (wrSel.cause ? (cause & wrData) : cause) | evtBits;
  end

  always_comb begin
    phyResp = '0;
    if (phyReg[PHY_OP_BIT]) begin
      phyResp[PHY_VAL_BIT] = 1'b1;
      unique case (phyReg[25:16])
        PHY_CODE_STATUS: phyResp[15:0] = PHY_STATUS_VAL;
        PHY_CODE_ID_HI:  phyResp[15:0] = PHY_ID_HI_VAL;
        PHY_CODE_ID_LO:  phyResp[15:0] = PHY_ID_LO_VAL;
        default:         phyResp[15:0] = '0;
      endcase
    end
  end

  always_comb begin
    rdNext = '0;
    if (rdSel.phy)   rdNext = phyResp;
    if (rdSel.port)  rdNext = DATA_W'(portOff) << PORT_OFF_BIT;
    if (rdSel.cause) rdNext = cause;
    if (rdSel.mask)  rdNext = mask;
    for (int i = 0; i < NUM_RX; i++) begin
      if (rdSel.firstRx[i]) rdNext = firstRx[i];
      if (rdSel.curRx[i])   rdNext = curRx[i];
    end
    for (int q = 0; q < NUM_TX; q++) begin
      if (rdSel.curTx[q]) rdNext = curTx[q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyReg  <= '0;
      cause   <= '0;
      mask    <= '0;
      portOff <= 1'b0;
      rdData  <= '0;
    end else begin
      cause  <= causeNext;
      rdData <= rdNext;
      if (wrSel.phy)  phyReg  <= wrData;
      if (wrSel.mask) mask    <= wrData;
      if (wrSel.port) portOff <= wrData[PORT_OFF_BIT];
    end
  end

  for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
    always_ff @(posedge clk) begin
      if (!rstN) begin
        firstRx[g] <= '0;
        curRx[g]   <= '0;
      end else begin
        if (wrSel.firstRx[g]) firstRx[g] <= wrData;
        if (wrSel.curRx[g])   curRx[g]   <= wrData;
      end
    end
    assign rxFirstPtr[g*DATA_W +: DATA_W] = firstRx[g];
    assign rxCurPtr[g*DATA_W +: DATA_W]   = curRx[g];
  end

  for (genvar g = 0; g < NUM_TX; g++) begin : g_tx
    always_ff @(posedge clk) begin
      if (!rstN)              curTx[g] <= '0;
      else if (wrSel.curTx[g]) curTx[g] <= wrData;
    end
    assign txCurPtr[g*DATA_W +: DATA_W] = curTx[g];
  end

  assign irq         = |(cause & mask);
  assign rxOffsetTwo = portOff;
endmodule

// File: rtl/ethregs_top.sv
module ethregs_top
  import ethregs_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  output logic                     irq,
  input  logic                     rxDoneEvt,
  input  logic [NUM_TX-1:0]        txDoneEvt,
  output logic                     txStartHi,
  output logic                     txStartLo,
  output logic [NUM_RX-1:0]        rxWorkLoad,
  output logic                     rxOffsetTwo,
  output logic [NUM_RX*DATA_W-1:0] rxFirstPtr,
  output logic [NUM_RX*DATA_W-1:0] rxCurPtr,
  output logic [NUM_TX*DATA_W-1:0] txCurPtr
);
  regSel_t wrSel, rdSel;

  ethregs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .cmdHiBit(wrData[CMD_HI_BIT]), .cmdLoBit(wrData[CMD_LO_BIT]),
    .wrSel(wrSel), .rdSel(rdSel),
    .txStartHi(txStartHi), .txStartLo(txStartLo), .rxWorkLoad(rxWorkLoad)
  );

  ethregs_dp dp_i (
    .clk(clk), .rstN(rstN), .wrSel(wrSel), .rdSel(rdSel), .wrData(wrData),
    .rxDoneEvt(rxDoneEvt), .txDoneEvt(txDoneEvt),
    .rdData(rdData), .irq(irq), .rxOffsetTwo(rxOffsetTwo),
    .rxFirstPtr(rxFirstPtr), .rxCurPtr(rxCurPtr), .txCurPtr(txCurPtr)
  );
endmodule

// File: rtl/ethregs_chk.sv
module ethregs_chk
  import ethregs_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic                     rdEn,
  input logic [ADDR_W-1:0]        addr,
  input logic [DATA_W-1:0]        wrData,
  input logic [DATA_W-1:0]        rdData,
  input logic                     txStartHi,
  input logic                     txStartLo,
  input logic [NUM_RX-1:0]        rxWorkLoad,
  input logic [NUM_RX*DATA_W-1:0] rxFirstPtr,
  input logic [NUM_RX*DATA_W-1:0] rxCurPtr,
  input logic [NUM_TX*DATA_W-1:0] txCurPtr
);
  logic cmdHi, cmdBoth;
  assign cmdHi   = wrEn && (addr == OFF_CMD) && wrData[CMD_HI_BIT];
  assign cmdBoth = cmdHi && wrData[CMD_LO_BIT];

  assert_hi_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdHi |=> txStartHi);

  assert_lo_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdBoth |=> ##1 txStartLo);

  assert_work_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_CUR_RX) |=> rxWorkLoad[0]);

  assert_work_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rxWorkLoad));

  assert_rd_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0));

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 12'h454) |=> ($stable(txCurPtr) && $stable(rxCurPtr) && $stable(rxFirstPtr)));
endmodule

bind ethregs_top ethregs_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .txStartHi(txStartHi), .txStartLo(txStartLo),
  .rxWorkLoad(rxWorkLoad), .rxFirstPtr(rxFirstPtr), .rxCurPtr(rxCurPtr),
  .txCurPtr(txCurPtr)
);

// File: tb/ethregs_top_tb_top.sv
module ethregs_top_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wrData = '0;
  logic         rxDoneEvt = 1'b0;
  logic [1:0]   txDoneEvt = '0;
  logic [31:0]  rdData;
  logic         irq, txStartHi, txStartLo, rxOffsetTwo;
  logic [3:0]   rxWorkLoad;
  logic [127:0] rxFirstPtr, rxCurPtr;
  logic [63:0]  txCurPtr;

  ethregs_top dut_i (.*);

  always #5 clk = ~clk;

  // Behavioural reference state
  logic [31:0] mPhy, mCause, mMask, mRd;
  logic        mPort, mHi, mLo, mLoLater;
  logic [3:0]  mWork;
  logic [31:0] mFirst [4];
  logic [31:0] mCur [4];
  logic [31:0] mTx [2];

  int    vectors = 0, miscompares = 0, cycles = 0;
  string curReq = "R1";
  bit    done = 0;

  function automatic logic [31:0] modelRead(logic [11:0] a);
    logic [31:0] r = '0;
    if (a == 12'h010 && mPhy[26]) begin
      r = 32'h0800_0000;
      if (mPhy[25:16] == 10'h021) r[15:0] = 16'h000C;
      if (mPhy[25:16] == 10'h041) r[15:0] = 16'h0141;
      if (mPhy[25:16] == 10'h061) r[15:0] = 16'h0E20;
    end
    if (a == 12'h408) r = {3'b0, mPort, 28'b0};
    if (a == 12'h450) r = mCause;
    if (a == 12'h458) r = mMask;
    for (int i = 0; i < 4; i++) begin
      if (a == 12'h480 + 12'(4*i)) r = mFirst[i];
      if (a == 12'h4A0 + 12'(4*i)) r = mCur[i];
    end
    for (int q = 0; q < 2; q++) if (a == 12'h4E0 + 12'(4*q)) r = mTx[q];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhy = 0; mCause = 0; mMask = 0; mRd = 0; mPort = 0;
      mHi = 0; mLo = 0; mLoLater = 0; mWork = 0;
      for (int i = 0; i < 4; i++) begin mFirst[i] = 0; mCur[i] = 0; end
      for (int q = 0; q < 2; q++) mTx[q] = 0;
    end else begin
      mRd = rdEn ? modelRead(addr) : 32'h0;
      mLo = mLoLater;
      mLoLater = 0;
      mHi = 0;
      mWork = 0;
      if (wrEn) begin
        if (addr == 12'h448) begin
          if (wrData[23]) mHi = 1;
          if (wrData[22] && wrData[23]) mLoLater = 1;
          else if (wrData[22]) mLo = 1;
        end
        if (addr == 12'h010) mPhy = wrData;
        if (addr == 12'h408) mPort = wrData[28];
        if (addr == 12'h450) mCause = mCause & wrData;
        if (addr == 12'h458) mMask = wrData;
        for (int i = 0; i < 4; i++) begin
          if (addr == 12'h480 + 12'(4*i)) mFirst[i] = wrData;
          if (addr == 12'h4A0 + 12'(4*i)) begin mCur[i] = wrData; mWork[i] = 1; end
        end
        for (int q = 0; q < 2; q++) if (addr == 12'h4E0 + 12'(4*q)) mTx[q] = wrData;
      end
      if (rxDoneEvt)    mCause[0] = 1;
      if (txDoneEvt[1]) mCause[2] = 1;
      if (txDoneEvt[0]) mCause[3] = 1;
    end
  end

  task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      chk({curReq, " rdData"}, 128'(rdData), 128'(mRd));
      chk("R4 irq", 128'(irq), 128'(|(mCause & mMask)));
      chk("R10 txStartHi", 128'(txStartHi), 128'(mHi));
      chk("R10 txStartLo", 128'(txStartLo), 128'(mLo));
      chk("R8 rxWorkLoad", 128'(rxWorkLoad), 128'(mWork));
      chk("R7 rxOffsetTwo", 128'(rxOffsetTwo), 128'(mPort));
      chk("R9 rxFirstPtr", rxFirstPtr, {mFirst[3], mFirst[2], mFirst[1], mFirst[0]});
      chk("R8 rxCurPtr", rxCurPtr, {mCur[3], mCur[2], mCur[1], mCur[0]});
      chk("R9 txCurPtr", 128'(txCurPtr), 128'({mTx[1], mTx[0]}));
    end
    if (cycles > 20000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0; addr = '0; wrData = '0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk); rdEn = 1; addr = a;
    @(negedge clk); rdEn = 0; addr = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rstN = 1;
    // R1: reset values
    curReq = "R1";
    rd(12'h450); rd(12'h458); rd(12'h4A0); rd(12'h010); idle(1);
    // R9: first-RX and TX pointers
    curReq = "R9";
    for (int i = 0; i < 4; i++) wr(12'h480 + 12'(4*i), 32'h1000_0100 + 32'(i));
    for (int q = 0; q < 2; q++) wr(12'h4E0 + 12'(4*q), 32'h2000_0040 * 32'(q + 1));
    for (int i = 0; i < 4; i++) rd(12'h480 + 12'(4*i));
    rd(12'h4E0); rd(12'h4E4);
    // R8: current-RX pointers and working-pointer load pulses
    curReq = "R8";
    for (int i = 0; i < 4; i++) wr(12'h4A0 + 12'(4*i), 32'hA5A5_0000 | 32'(i << 4));
    for (int i = 0; i < 4; i++) rd(12'h4A0 + 12'(4*i));
    // R7: receive offset bit
    curReq = "R7";
    wr(12'h408, 32'hFFFF_FFFF); rd(12'h408);
    wr(12'h408, 32'hEFFF_FFFF); rd(12'h408);
    // R5: PHY read without opcode
    curReq = "R5";
    wr(12'h010, 32'h0021_0000); rd(12'h010);
    // R6: canned PHY responses
    curReq = "R6";
    wr(12'h010, 32'h0421_0000); rd(12'h010);
    wr(12'h010, 32'h0441_0000); rd(12'h010);
    wr(12'h010, 32'h0461_0000); rd(12'h010);
    wr(12'h010, 32'h0401_1234); rd(12'h010);
    // R3: events set cause bits
    curReq = "R3";
    @(negedge clk); rxDoneEvt = 1;
    @(negedge clk); rxDoneEvt = 0; txDoneEvt = 2'b01;
    @(negedge clk); txDoneEvt = 2'b10;
    @(negedge clk); txDoneEvt = 2'b00;
    rd(12'h450);
    // R4: mask and interrupt level
    curReq = "R4";
    wr(12'h458, 32'h0000_0001); rd(12'h458); idle(2);
    // R2: AND-clear of cause
    curReq = "R2";
    wr(12'h450, 32'hFFFF_FFFE); rd(12'h450);
    wr(12'h458, 32'h0000_0008); idle(1);
    wr(12'h450, 32'h0000_0000); rd(12'h450);
    // R3: event wins over a clear in the same cycle
    curReq = "R3";
    wr(12'h458, 32'h0000_0001);
    @(negedge clk); wrEn = 1; addr = 12'h450; wrData = 32'h0; rxDoneEvt = 1;
    @(negedge clk); wrEn = 0; addr = '0; rxDoneEvt = 0;
    rd(12'h450);
    // R10: transmit start commands
    curReq = "R10";
    wr(12'h448, 32'h0080_0000); idle(2);
    wr(12'h448, 32'h0040_0000); idle(2);
    wr(12'h448, 32'h00C0_0000); idle(3);
    // R11: unmapped offsets and write-only command register
    curReq = "R11";
    wr(12'h454, 32'hFFFF_FFFF); wr(12'h490, 32'hFFFF_FFFF); wr(12'h4EC, 32'hFFFF_FFFF);
    rd(12'h454); rd(12'h490); rd(12'h448); rd(12'hFFC);
    // R12: no read strobe gives zero data
    curReq = "R12";
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule